// File: doc/BRIEF.md
# Keyed Indexed Configuration Register Port

This block is a small configuration register file that sits on an 8-bit host bus with three decoded addresses. A host gets to it in three steps. First it writes an unlock key to the key register. Next it writes a register number to the index register. Then it reads or writes the selected register through the data register. Accesses through the data register reach the register file only while the key register holds the valid key.

The register file has one control register at index 0Ch. That register holds the following fields:
- a clock-source select for each of two serial ports;
- the bit that chooses which key value is valid;
- two enable bits for a parallel-port extension pin.

The fields drive registered control outputs to the rest of the chip. The key-select bit is loaded from a strap input at reset, so board wiring chooses the key in force at power-up. Software can change that bit later, and the new key applies at once.

Top module: `cfg_keyport`

## Requirements
- R1: Host address 0 is the key register and address 1 is the index register. Both are written when `host_cs` and `host_wr` are high at a clock edge, and both read back their stored value. Address 2 is the data port. Address 3 reads 00h, and writes to it have no effect. After reset the key register and the index register both hold 00h.
- R2: The port is unlocked only when the key register holds exactly 88h while the key-select bit is 0, or exactly 89h while the key-select bit is 1. Every other key value leaves the port locked.
- R3: Reset loads the key-select bit (control bit 5, output `key_sel`) from `strap_keysel`. The bench drives the strap input directly, and an unconnected strap is expected to be pulled high on the board.
- R4: While the port is unlocked and the index is 0Ch, the data port reads and writes the control register. Bits 4, 3 and 2 of that register are reserved and always read as 0.
- R5: While the port is locked, a write to the data port changes nothing, and a read of the data port returns FFh.
- R6: While the port is unlocked, any index other than 0Ch (0Bh among them) reads 00h through the data port, and a write through the data port to such an index changes no state.
- R7: Control bit 7 drives `uart_a_fast` and bit 6 drives `uart_b_fast`. A value of 0 selects the reference clock divided by 13, and 1 selects the undivided reference clock. Both bits reset to 0.
- R8: Control bit 1 drives `pext_ecp_en` and bit 0 drives `pext_ecpepp_en`. A value of 1 activates the extension pin in that port mode. Both bits reset to 0.
- R9: When a data-port write changes the key-select bit, the new valid key applies from the next cycle on. If the key register no longer matches, the port is locked from that cycle.
- R10: Writing any value other than the valid key to the key register locks the port from the next cycle on.
- R11: The read data is combinational and valid in the same cycle that `host_cs` and `host_rd` are high. When no read is strobed, the read data is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_keysel | input | 1 | Reset value of the key-select bit |
| host_cs | input | 1 | Chip select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 2 | Host register address (0 key, 1 index, 2 data) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, same cycle as the read strobe |
| uart_a_fast | output | 1 | Serial port A clock select |
| uart_b_fast | output | 1 | Serial port B clock select |
| key_sel | output | 1 | Current key-select bit |
| pext_ecp_en | output | 1 | Extension pin enable in ECP mode |
| pext_ecpepp_en | output | 1 | Extension pin enable in ECP/EPP mode |

## Verification
A host write is captured at the clock edge where its strobe is high. Its effects appear in the cycle after that edge: on the control outputs, on the lock state, and on any later read. A read has no latency: `host_rdata` follows the strobe within the same cycle.

The bench changes every input at the falling edge. It performs each write as one full strobed cycle and only then reads, so every read observes the state after the write. It samples a read 1 ns after the read strobe is raised, which is before the next rising edge. It samples the control outputs in the cycle after the write that set them.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
  localparam int HW = 2;

  localparam logic [HW-1:0] HA_KEY   = 2'd0;
  localparam logic [HW-1:0] HA_INDEX = 2'd1;
  localparam logic [HW-1:0] HA_DATA  = 2'd2;

  // control register bit positions (outputs decode these)
  localparam int B_UART_A = 7;
  localparam int B_UART_B = 6;
  localparam int B_KSEL   = 5;
  localparam int B_ECP    = 1;
  localparam int B_ECPEPP = 0;
endpackage

// File: rtl/cfg_key_gate.sv
module cfg_key_gate #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY_BASE = 8'h88
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  input  logic          key_sel,
  output logic [DW-1:0] key_q,
  output logic          unlocked
);
  logic [DW-1:0] valid_key;

  always_ff @(posedge clk) begin
    if (rst)         key_q <= '0;
    else if (key_wr) key_q <= wdata;
  end

  // lowest key bit follows the key-select bit
  assign valid_key = {KEY_BASE[DW-1:1], key_sel};
  assign unlocked  = (key_q == valid_key);

  AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(key_wr) || !$stable(key_sel))); // R2
  AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (key_wr && (wdata != valid_key)) |=> !unlocked); // R10
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
  parameter int DW = 8,
  parameter logic [DW-1:0] CTRL_INDEX = 8'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] index_q,
  output logic          sel_ctrl
);
  always_ff @(posedge clk) begin
    if (rst)         index_q <= '0;
    else if (idx_wr) index_q <= wdata;
  end

  assign sel_ctrl = (index_q == CTRL_INDEX);
endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_keyport_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CTRL_MASK = 8'hE3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] reset_val;

  always_comb begin
    reset_val         = '0;
    reset_val[B_KSEL] = strap;
  end

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= reset_val;
    else if (wr_en) ctrl_q <= wdata & CTRL_MASK;
  end

  AST_STRAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_q[B_KSEL] == $past(strap))); // R3
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q == ($past(wdata) & CTRL_MASK))); // R4
  AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_MASK) == '0); // R4
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY_BASE    = 8'h88,
  parameter logic [DW-1:0] CTRL_INDEX  = 8'h0C,
  parameter logic [DW-1:0] CTRL_MASK   = 8'hE3,
  parameter logic [DW-1:0] LOCKED_READ = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_keysel,
  input  logic          host_cs,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [HW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          uart_a_fast,
  output logic          uart_b_fast,
  output logic          key_sel,
  output logic          pext_ecp_en,
  output logic          pext_ecpepp_en
);
  logic          wr_cyc, rd_cyc;
  logic          key_wr, idx_wr, data_wr, ctrl_wr;
  logic [DW-1:0] key_q, index_q, ctrl_q;
  logic          unlocked, sel_ctrl;

  assign wr_cyc  = host_cs && host_wr;
  assign rd_cyc  = host_cs && host_rd;
  assign key_wr  = wr_cyc && (host_addr == HA_KEY);
  assign idx_wr  = wr_cyc && (host_addr == HA_INDEX);
  assign data_wr = wr_cyc && (host_addr == HA_DATA);
  assign ctrl_wr = data_wr && unlocked && sel_ctrl;

  cfg_key_gate #(.DW(DW), .KEY_BASE(KEY_BASE)) key_i (
    .clk(clk), .rst(rst), .key_wr(key_wr), .wdata(host_wdata),
    .key_sel(ctrl_q[B_KSEL]), .key_q(key_q), .unlocked(unlocked));

  cfg_index_reg #(.DW(DW), .CTRL_INDEX(CTRL_INDEX)) idx_i (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(host_wdata),
    .index_q(index_q), .sel_ctrl(sel_ctrl));

  cfg_ctrl_reg #(.DW(DW), .CTRL_MASK(CTRL_MASK)) ctrl_i (
    .clk(clk), .rst(rst), .strap(strap_keysel), .wr_en(ctrl_wr),
    .wdata(host_wdata), .ctrl_q(ctrl_q));

  always_comb begin
    host_rdata = '0;
    if (rd_cyc) begin
      case (host_addr)
        HA_KEY:   host_rdata = key_q;
        HA_INDEX: host_rdata = index_q;
        HA_DATA: begin
          if (!unlocked)     host_rdata = LOCKED_READ;
          else if (sel_ctrl) host_rdata = ctrl_q;
          else               host_rdata = '0;
        end
        default:  host_rdata = '0;
      endcase
    end
  end

  assign uart_a_fast    = ctrl_q[B_UART_A];
  assign uart_b_fast    = ctrl_q[B_UART_B];
  assign key_sel        = ctrl_q[B_KSEL];
  assign pext_ecp_en    = ctrl_q[B_ECP];
  assign pext_ecpepp_en = ctrl_q[B_ECPEPP];

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !unlocked) |=> $stable(ctrl_q)); // R5
  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc && host_addr == HA_DATA && !unlocked) |-> host_rdata == LOCKED_READ); // R5
  AST_RSVD_INDEX_WRITE: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !sel_ctrl) |=> $stable(ctrl_q)); // R6
  AST_KEYSEL_RELOCK: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && (host_wdata[B_KSEL] != ctrl_q[B_KSEL]) && key_q[0] == ctrl_q[B_KSEL])
      |=> !unlocked); // R9
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_cyc |-> host_rdata == '0); // R11
endmodule

// File: tb/cfg_keyport_tb.sv
`timescale 1ns/1ps
module cfg_keyport_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap = 1'b1;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ua, ub, ks, ecp, epp;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] ctrl_m;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  cfg_keyport dut_i (
    .clk(clk), .rst(rst), .strap_keysel(strap), .host_cs(cs), .host_wr(wr),
    .host_rd(rd), .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .uart_a_fast(ua), .uart_b_fast(ub), .key_sel(ks),
    .pext_ecp_en(ecp), .pext_ecpepp_en(epp));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_outs(input string req);
    check(req, {ua, ub, ks, 3'b000, ecp, epp}, ctrl_m);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    ctrl_m = 8'h20;
    // reset state
    hread(2'd0, rv); check("R1 key reset", rv, 8'h00);
    hread(2'd1, rv); check("R1 index reset", rv, 8'h00);
    check_outs("R3 R7 R8 reset outputs");
    hread(2'd2, rv); check("R5 locked read", rv, 8'hFF);
    hread(2'd3, rv); check("R1 spare read", rv, 8'h00);
    @(negedge clk); #1 check("R11 idle rdata", rdata, 8'h00);

    // locked write ignored, then unlock and read back
    hwrite(2'd1, 8'h0C);
    hwrite(2'd2, 8'hFF);
    hwrite(2'd3, 8'hC3);
    check_outs("R5 locked write outputs");
    hwrite(2'd0, 8'h89);
    hread(2'd2, rv); check("R5 locked write ignored", rv, 8'h20);
    hread(2'd1, rv); check("R1 index readback", rv, 8'h0C);

    // key sweep with key-select 1
    for (int k = 0; k < 256; k++) begin
      hwrite(2'd0, 8'(k));
      hread(2'd2, rv);
      check("R2 key sweep ks1", rv, (k == 8'h89) ? ctrl_m : 8'hFF);
    end
    hread(2'd0, rv); check("R1 key readback", rv, 8'hFF);

    // flip key-select while unlocked
    hwrite(2'd0, 8'h89);
    hwrite(2'd2, 8'h00);
    ctrl_m = 8'h00;
    hread(2'd2, rv); check("R9 keysel change relocks", rv, 8'hFF);
    check_outs("R9 keysel output");
    for (int k = 0; k < 256; k++) begin
      hwrite(2'd0, 8'(k));
      hread(2'd2, rv);
      check("R2 key sweep ks0", rv, (k == 8'h88) ? ctrl_m : 8'hFF);
    end

    // control register sweep
    for (int v = 0; v < 256; v++) begin
      hwrite(2'd0, {7'h44, ctrl_m[5]});
      hwrite(2'd2, 8'(v));
      ctrl_m = 8'(v) & 8'hE3;
      check_outs("R7 R8 ctrl outputs");
      hwrite(2'd0, {7'h44, ctrl_m[5]});
      hread(2'd2, rv);
      check("R4 ctrl readback", rv, ctrl_m);
    end

    // index sweep
    hwrite(2'd0, {7'h44, ctrl_m[5]});
    hwrite(2'd2, 8'hC3);
    ctrl_m = 8'hC3;
    hwrite(2'd0, 8'h88);
    for (int i = 0; i < 256; i++) begin
      hwrite(2'd1, 8'(i));
      hread(2'd2, rv);
      check("R6 index sweep read", rv, (i == 8'h0C) ? ctrl_m : 8'h00);
      if (i != 8'h0C) hwrite(2'd2, 8'h24);
    end
    check_outs("R6 reserved writes outputs");
    hwrite(2'd1, 8'h0C);
    hread(2'd2, rv); check("R6 reserved writes ignored", rv, ctrl_m);

    // relock
    hwrite(2'd0, 8'h89);
    hread(2'd2, rv); check("R10 relock", rv, 8'hFF);
    hwrite(2'd2, 8'h00);
    hwrite(2'd0, 8'h88);
    hread(2'd2, rv); check("R10 unlock again", rv, ctrl_m);

    // strap low
    do_reset(1'b0);
    ctrl_m = 8'h00;
    check_outs("R3 strap low outputs");
    hwrite(2'd1, 8'h0C);
    hwrite(2'd0, 8'h89);
    hread(2'd2, rv); check("R3 strap low 89 locked", rv, 8'hFF);
    hwrite(2'd0, 8'h88);
    hread(2'd2, rv); check("R3 strap low 88 unlocks", rv, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule